// File: doc/BRIEF.md
# Cascadable Cell Array Multiplier

This block multiplies two unsigned operands of equal width and returns their full-width product. It is purely combinational and has no clock. The structure is a square grid of one identical one-bit cell. Each cell ANDs one bit of the multiplicand with one bit of the multiplier. It then adds that bit to a partial-product bit arriving from the row above and to a carry arriving from its right-hand neighbour. The result is a sum bit and a carry bit.

Operand bits are not fanned out from the top. Every cell hands its multiplicand bit down to the cell below it and its multiplier bit across to the next cell in its row. The copies that leave the far edges of the grid come out as port outputs, so that a neighbouring tile can be chained onto them. Cells on the upper edge receive a zero partial product. The first cell of every row receives a zero carry. The last carry of the bottom row forms the most significant product bit.

Top module: `arr_mul_top`

## Requirements
- R1: For any operands, `product` equals the unsigned product `mcand * mplier`, zero-extended to 2*WIDTH bits.
- R2: With the default WIDTH of 2, all 16 operand pairs from 0x0 through 3x3 give the exact product.
- R3: When either operand is zero, every bit of `product` is zero.
- R4: Bit 0 of `product` equals the AND of bit 0 of each operand.
- R5: When one operand equals 1, `product` equals the other operand in its low WIDTH bits, and its upper WIDTH bits are zero.
- R6: `mcand_thru` equals `mcand` after the bits travel down every row, and `mplier_thru` equals `mplier` after the bits travel along every column.
- R7: When both operands are all ones, `product` equals (2^WIDTH-1)^2. The top bit of the product comes from the final carry of the last row and is set in this case.
- R8: A WIDTH of 3 gives the exact product for all 64 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product |
| mcand_thru | output | WIDTH | Multiplicand copy leaving the bottom row |
| mplier_thru | output | WIDTH | Multiplier copy leaving the last column, one bit per row |

## Verification
The bench sweeps every operand pair at widths 2 and 3. This sweep reaches the cases where a miswired edge would show. If an edge cell took a live partial product or carry instead of zero, products with a zero operand or a one operand would come out nonzero or shifted. If the final carry were dropped, the all-ones case would lose its top bit: 3x3 would read 1 instead of 9. A broken pass-through chain would show up as a pass-through output that differs from its operand, or as wrong high-order bits once a row reads a stale operand.

// File: rtl/amul_pkg.sv
package amul_pkg;

  // Width of a full product for a given operand width.
  function automatic int unsigned prod_width(input int unsigned w);
    return 2 * w;
  endfunction

  // Sum and carry produced by one adding stage.
  typedef struct packed {
    logic carry;
    logic sum;
  } amul_add_t;

endpackage

// File: rtl/amul_full_add.sv
module amul_full_add
  import amul_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);

  amul_add_t res;

  always_comb begin
    res.sum   = a_i ^ b_i ^ c_i;
    res.carry = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end

  assign s_o  = res.sum;
  assign co_o = res.carry;

endmodule

// File: rtl/amul_cell.sv
module amul_cell (
  input  logic m_i,
  input  logic q_i,
  input  logic pp_i,
  input  logic cin_i,
  output logic p_o,
  output logic cout_o,
  output logic m_o,
  output logic q_o
);

  logic bit_prod;

  assign bit_prod = m_i & q_i;

  amul_full_add add_i (
    .a_i  (pp_i),
    .b_i  (bit_prod),
    .c_i  (cin_i),
    .s_o  (p_o),
    .co_o (cout_o)
  );

  // Operand bits travel on to the neighbouring cells.
  assign m_o = m_i;
  assign q_o = q_i;

endmodule

// File: rtl/arr_mul_top.sv
module arr_mul_top
  import amul_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0]                    mcand,
  input  logic [WIDTH-1:0]                    mplier,
  output logic [prod_width(WIDTH)-1:0]        product,
  output logic [WIDTH-1:0]                    mcand_thru,
  output logic [WIDTH-1:0]                    mplier_thru
);

  localparam int unsigned PW  = prod_width(WIDTH);
  localparam int unsigned TOP = WIDTH - 1;

  logic [PW-1:0] prod_w;

  // Row r uses multiplier bit r; column c uses multiplicand bit c.
  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
      logic m_in, q_in, pp_in, ci_in;
      logic p_out, co_out, m_out, q_out;

      // Multiplicand enters at the top and moves down.
      if (r == 0) begin : g_m_edge
        assign m_in = mcand[c];
      end else begin : g_m_link
        assign m_in = g_row[r-1].g_col[c].m_out;
      end

      // Multiplier enters at the left and moves across.
      if (c == 0) begin : g_q_edge
        assign q_in = mplier[r];
      end else begin : g_q_link
        assign q_in = g_row[r].g_col[c-1].q_out;
      end

      // Partial product: zero on the top row, shifted sum below,
      // the previous row's final carry into the last column.
      if (r == 0) begin : g_pp_edge
        assign pp_in = 1'b0;
      end else if (c == TOP) begin : g_pp_carry
        assign pp_in = g_row[r-1].g_col[c].co_out;
      end else begin : g_pp_sum
        assign pp_in = g_row[r-1].g_col[c+1].p_out;
      end

      // Carry ripples across a row; the first cell starts at zero.
      if (c == 0) begin : g_ci_edge
        assign ci_in = 1'b0;
      end else begin : g_ci_link
        assign ci_in = g_row[r].g_col[c-1].co_out;
      end

      amul_cell cell_i (
        .m_i    (m_in),
        .q_i    (q_in),
        .pp_i   (pp_in),
        .cin_i  (ci_in),
        .p_o    (p_out),
        .cout_o (co_out),
        .m_o    (m_out),
        .q_o    (q_out)
      );
    end

    // Low product bits come from the first cell of each row.
    assign prod_w[r] = g_row[r].g_col[0].p_out;
    // Multiplier copies leaving the right edge.
    assign mplier_thru[r] = g_row[r].g_col[TOP].q_out;
  end

  // High product bits come from the bottom row.
  for (genvar c = 1; c < WIDTH; c++) begin : g_hi
    assign prod_w[TOP + c] = g_row[TOP].g_col[c].p_out;
  end
  assign prod_w[PW-1] = g_row[TOP].g_col[TOP].co_out;

  for (genvar c = 0; c < WIDTH; c++) begin : g_mthru
    assign mcand_thru[c] = g_row[TOP].g_col[c].m_out;
  end

  assign product = prod_w;

endmodule

// File: rtl/amul_chk.sv
module amul_chk #(
  parameter int unsigned WIDTH = 2
) (
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product,
  input logic [WIDTH-1:0]   mcand_thru,
  input logic [WIDTH-1:0]   mplier_thru
);

  localparam int unsigned PW = 2 * WIDTH;

  logic [PW-1:0] ext_a, ext_b, all_one_sq;
  logic [WIDTH-1:0] ones;

  always_comb begin
    ext_a      = PW'(mcand);
    ext_b      = PW'(mplier);
    ones       = '1;
    all_one_sq = PW'(ones) * PW'(ones);
  end

  always_comb begin
    assert_exact_product_R1: assert (product == ext_a * ext_b)
      else $error("R1 product mismatch");
    assert_zero_operand_R3: assert (!((mcand == '0) || (mplier == '0)) || (product == '0))
      else $error("R3 zero operand gave nonzero product");
    assert_low_bit_R4: assert (product[0] == (mcand[0] & mplier[0]))
      else $error("R4 low bit wrong");
    assert_unit_operand_R5: assert (!(mplier == WIDTH'(1)) || (product == ext_a))
      else $error("R5 multiply by one wrong");
    assert_pass_through_R6: assert ((mcand_thru == mcand) && (mplier_thru == mplier))
      else $error("R6 pass-through wrong");
    assert_full_scale_R7: assert (!((mcand == ones) && (mplier == ones)) ||
                                  ((product == all_one_sq) && product[PW-1]))
      else $error("R7 full scale wrong");
  end

endmodule

bind arr_mul_top amul_chk #(.WIDTH(WIDTH)) chk_i (
  .mcand       (mcand),
  .mplier      (mplier),
  .product     (product),
  .mcand_thru  (mcand_thru),
  .mplier_thru (mplier_thru)
);

// File: tb/arr_mul_top_tb_top.sv
`timescale 1ns/1ps
module arr_mul_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0] a2, b2, mt2, qt2;
  logic [3:0] p2;
  logic [2:0] a3, b3, mt3, qt3;
  logic [5:0] p3;

  arr_mul_top #(.WIDTH(2)) dut_i (
    .mcand(a2), .mplier(b2), .product(p2), .mcand_thru(mt2), .mplier_thru(qt2)
  );
  arr_mul_top #(.WIDTH(3)) dut_w3_i (
    .mcand(a3), .mplier(b3), .product(p3), .mcand_thru(mt3), .mplier_thru(qt3)
  );

  typedef struct { int w; int a; int b; } vec_t;
  vec_t pend[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: plain integer arithmetic on each queued pair.
  always @(negedge clk) begin
    if (!rst && pend.size() > 0) begin
      vec_t v;
      int exp, act, maxv, mt, qt;
      string tag;
      v    = pend.pop_front();
      exp  = v.a * v.b;
      maxv = (1 << v.w) - 1;
      if (v.w == 2) begin
        act = int'(p2); mt = int'(mt2); qt = int'(qt2);
      end else begin
        act = int'(p3); mt = int'(mt3); qt = int'(qt3);
      end
      if (v.a == 0 || v.b == 0)           tag = "R3";
      else if (v.a == 1 || v.b == 1)      tag = "R5";
      else if (v.a == maxv && v.b == maxv) tag = "R7";
      else if (v.w == 2)                  tag = "R2";
      else                                tag = "R8";
      check(tag, act, exp);
      check(v.w == 2 ? "R1" : "R8", act, exp);
      check("R4", act & 1, (v.a & v.b) & 1);
      check("R6", mt, v.a);
      check("R6", qt, v.b);
    end
  end

  task automatic apply(input int w, input int a, input int b);
    vec_t v;
    @(posedge clk);
    #1;
    if (w == 2) begin a2 = 2'(a); b2 = 2'(b); end
    else        begin a3 = 3'(a); b3 = 3'(b); end
    v.w = w; v.a = a; v.b = b;
    pend.push_back(v);
  endtask

  initial begin
    a2 = '0; b2 = '0; a3 = '0; b3 = '0;
    repeat (3) @(posedge clk);
    #1;
    // Quiescent state with both operands zero (R3).
    check("R3", int'(p2), 0);
    check("R3", int'(p3), 0);
    rst = 1'b0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        apply(2, a, b);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        apply(3, a, b);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule